// File: doc/BRIEF.md
# SIMT Divergence Reconvergence Stack

This block tracks control flow for a single warp of `LANES` threads when those threads take different directions at a branch. It keeps a small hardware stack. Each row holds three things: the PC at which its threads join again, the PC that the row will fetch next, and the mask of lanes that belong to the row. The row on top of the stack drives the warp's fetch PC. Its mask chooses which lanes execute the instruction being fetched.

The pipeline reports two kinds of event. A resolved branch arrives with a per-lane taken mask, the taken target, the fall-through target and the join PC. A plain PC advance arrives with the PC that follows a non-branch instruction. When a branch splits the active lanes, the block rewrites the top row so that it resumes at the join PC. It then pushes one row for each path, and the path with more lanes goes on top. When the top row's PC reaches its own join PC, the row is removed and the row beneath takes over.

Top module: `simt_reconv_stack`

## Requirements
- R1: Reset leaves one row on the stack: `depth` = 1, `fetch_pc` = `START_PC`, `active_mask` all ones, `overflow_err` = 0. This bottom row has a join PC of zero.
- R2: A PC advance (`adv_valid` = 1, `br_valid` = 0) that does not cause a pop sets `fetch_pc` to `adv_pc` on the next cycle. `active_mask` and `depth` stay unchanged.
- R3: If every active lane agrees at a branch, the branch is uniform. All active lanes taken gives `br_taken_pc` as the next `fetch_pc`. No active lane taken gives `br_fall_pc`. Nothing is pushed.
- R4: On a divergent branch, both the taken subset and the not-taken subset of the active lanes are non-empty. The top row then resumes at `br_reconv_pc`, two rows tagged with `br_reconv_pc` are pushed, and `depth` grows by 2. The new top is the subset with more lanes, and it carries that subset's mask and target.
- R5: If both subsets of a divergent branch have the same lane count, the taken path goes on top.
- R6: When the top path pops, the other path of the same branch becomes the top, with its own mask and target.
- R7: A pop occurs when an advance or a uniform branch would set the top row's next PC equal to that row's join PC while `depth` > 1. In that case `depth` drops by 1, and fetch resumes from the row below at the PC stored there.
- R8: The bottom row never pops. At `depth` = 1, any advance or uniform branch just updates `fetch_pc`, including one whose target is 0.
- R9: A divergent branch that arrives when fewer than two rows are free leaves the stack unchanged and sets `overflow_err`. The flag stays set until reset.
- R10: When `br_valid` and `adv_valid` are both high in the same cycle, the branch is applied and the advance is ignored.
- R11: Bits of `br_taken_mask` in lanes outside `active_mask` have no effect on whether a branch diverges, on lane counts, or on the masks that are pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid | input | 1 | A resolved branch is presented this cycle |
| br_taken_mask | input | LANES | Per-lane branch outcome, 1 = taken |
| br_taken_pc | input | PC_W | Target of the taken path |
| br_fall_pc | input | PC_W | Target of the not-taken path |
| br_reconv_pc | input | PC_W | PC at which the two paths join again |
| adv_valid | input | 1 | A non-branch PC advance is presented |
| adv_pc | input | PC_W | PC that follows the completed instruction |
| fetch_pc | output | PC_W | Next PC of the top row |
| active_mask | output | LANES | Lane mask of the top row |
| depth | output | $clog2(DEPTH+1) | Number of rows on the stack |
| overflow_err | output | 1 | Sticky flag for a split rejected because the stack is full |

## Verification
The bench steers the hard orderings. A tied split checks that the taken path goes on top; a design that ordered ties the other way would fetch the fall-through target first. A lopsided split checks that the larger subset goes on top; a design that always placed the taken path on top would fail there. Nested splits are unwound one pop at a time, which shows whether the rewritten join PC in the lower row is reached, and whether the sibling path surfaces with its own mask. The remaining cases are a split into a nearly full stack, which must leave everything untouched and latch the error; a branch and an advance in the same cycle; taken bits in inactive lanes, which a careless design would count; and an advance to PC 0 at the bottom row, which a design that compared against the empty join PC would wrongly pop.

// File: rtl/simt_stack_pkg.sv
package simt_stack_pkg;

    // Kind of stack update chosen in a cycle
    typedef enum logic [1:0] {
        OP_HOLD   = 2'd0,
        OP_SET    = 2'd1,
        OP_SPLIT  = 2'd2,
        OP_REJECT = 2'd3
    } stk_op_e;

endpackage

// File: rtl/simt_lane_count.sv
module simt_lane_count #(
    parameter int LANES = 4,
    localparam int CNT_W = $clog2(LANES + 1)
) (
    input  logic [LANES-1:0] lanes,
    output logic [CNT_W-1:0] count
);

    always_comb begin
        count = '0;
        for (int i = 0; i < LANES; i++) begin
            count = count + CNT_W'(lanes[i]);
        end
    end

endmodule

// File: rtl/simt_branch_split.sv
module simt_branch_split #(
    parameter int LANES = 4
) (
    input  logic [LANES-1:0] cur_mask,
    input  logic [LANES-1:0] taken_mask,
    output logic [LANES-1:0] taken_sub,
    output logic [LANES-1:0] fall_sub,
    output logic             divergent,
    output logic             any_taken,
    output logic             taken_first
);

    localparam int CNT_W = $clog2(LANES + 1);

    logic [CNT_W-1:0] taken_cnt;
    logic [CNT_W-1:0] fall_cnt;

    assign taken_sub = cur_mask & taken_mask;
    assign fall_sub  = cur_mask & ~taken_mask;

    simt_lane_count #(.LANES(LANES)) u_cnt_taken (
        .lanes (taken_sub),
        .count (taken_cnt)
    );

    simt_lane_count #(.LANES(LANES)) u_cnt_fall (
        .lanes (fall_sub),
        .count (fall_cnt)
    );

    assign any_taken   = |taken_sub;
    assign divergent   = any_taken && (|fall_sub);
    // equal counts favour the taken path
    assign taken_first = taken_cnt >= fall_cnt;

endmodule

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack
    import simt_stack_pkg::*;
#(
    parameter int          LANES    = 4,
    parameter int          PC_W     = 16,
    parameter int          DEPTH    = 8,
    parameter logic [15:0] START_PC = 16'h0000,
    localparam int         SP_W     = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             br_valid,
    input  logic [LANES-1:0] br_taken_mask,
    input  logic [PC_W-1:0]  br_taken_pc,
    input  logic [PC_W-1:0]  br_fall_pc,
    input  logic [PC_W-1:0]  br_reconv_pc,
    input  logic             adv_valid,
    input  logic [PC_W-1:0]  adv_pc,
    output logic [PC_W-1:0]  fetch_pc,
    output logic [LANES-1:0] active_mask,
    output logic [SP_W-1:0]  depth,
    output logic             overflow_err
);

    localparam int IDX_W = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][PC_W-1:0]  join_pc;
        logic [DEPTH-1:0][PC_W-1:0]  next_pc;
        logic [DEPTH-1:0][LANES-1:0] lanes;
        logic [SP_W-1:0]             rows;
        logic                        err;
    } stk_state_t;

    stk_state_t s_d, s_q;

    logic [SP_W-1:0]  rows_m1;
    logic [IDX_W-1:0] top_idx;
    logic [IDX_W-1:0] idx_lo;
    logic [IDX_W-1:0] idx_hi;

    assign rows_m1 = s_q.rows - SP_W'(1);
    assign top_idx = rows_m1[IDX_W-1:0];
    assign idx_lo  = top_idx + IDX_W'(1);
    assign idx_hi  = top_idx + IDX_W'(2);

    logic [LANES-1:0] taken_sub, fall_sub;
    logic             divergent, any_taken, taken_first;

    simt_branch_split #(.LANES(LANES)) u_split (
        .cur_mask    (s_q.lanes[top_idx]),
        .taken_mask  (br_taken_mask),
        .taken_sub   (taken_sub),
        .fall_sub    (fall_sub),
        .divergent   (divergent),
        .any_taken   (any_taken),
        .taken_first (taken_first)
    );

    stk_op_e         op_d;
    logic [PC_W-1:0] set_pc_d;
    logic            has_room;

    assign has_room = s_q.rows <= SP_W'(DEPTH - 2);

    // choose the operation for this cycle
    always_comb begin
        op_d     = OP_HOLD;
        set_pc_d = adv_pc;
        if (br_valid) begin
            if (divergent) begin
                op_d = has_room ? OP_SPLIT : OP_REJECT;
            end else begin
                op_d     = OP_SET;
                set_pc_d = any_taken ? br_taken_pc : br_fall_pc;
            end
        end else if (adv_valid) begin
            op_d = OP_SET;
        end
    end

    // compute the next stack state
    always_comb begin
        s_d = s_q;
        unique case (op_d)
            OP_SET: begin
                if (s_q.rows > SP_W'(1) && set_pc_d == s_q.join_pc[top_idx]) begin
                    s_d.rows = s_q.rows - SP_W'(1);
                end else begin
                    s_d.next_pc[top_idx] = set_pc_d;
                end
            end
            OP_SPLIT: begin
                s_d.next_pc[top_idx] = br_reconv_pc;
                s_d.join_pc[idx_lo]  = br_reconv_pc;
                s_d.join_pc[idx_hi]  = br_reconv_pc;
                if (taken_first) begin
                    s_d.next_pc[idx_hi] = br_taken_pc;
                    s_d.lanes[idx_hi]   = taken_sub;
                    s_d.next_pc[idx_lo] = br_fall_pc;
                    s_d.lanes[idx_lo]   = fall_sub;
                end else begin
                    s_d.next_pc[idx_hi] = br_fall_pc;
                    s_d.lanes[idx_hi]   = fall_sub;
                    s_d.next_pc[idx_lo] = br_taken_pc;
                    s_d.lanes[idx_lo]   = taken_sub;
                end
                s_d.rows = s_q.rows + SP_W'(2);
            end
            OP_REJECT: begin
                s_d.err = 1'b1;
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q            <= '0;
            s_q.rows       <= SP_W'(1);
            s_q.next_pc[0] <= PC_W'(START_PC);
            s_q.lanes[0]   <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign fetch_pc     = s_q.next_pc[top_idx];
    assign active_mask  = s_q.lanes[top_idx];
    assign depth        = s_q.rows;
    assign overflow_err = s_q.err;

endmodule

// File: rtl/simt_stack_checker.sv
module simt_stack_checker #(
    parameter int LANES = 4,
    parameter int PC_W  = 16,
    parameter int DEPTH = 8,
    localparam int SP_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             br_valid,
    input logic [LANES-1:0] br_taken_mask,
    input logic [PC_W-1:0]  br_taken_pc,
    input logic [PC_W-1:0]  br_fall_pc,
    input logic             adv_valid,
    input logic [PC_W-1:0]  fetch_pc,
    input logic [LANES-1:0] active_mask,
    input logic [SP_W-1:0]  depth,
    input logic             overflow_err
);

    logic [LANES-1:0] tk, fl;
    logic             div, roomy;
    assign tk    = br_taken_mask & active_mask;
    assign fl    = ~br_taken_mask & active_mask;
    assign div   = (tk != '0) && (fl != '0);
    assign roomy = int'(depth) <= DEPTH - 2;

    a_r1_depth_range: assert property (@(posedge clk) disable iff (!rst_n)
        depth >= SP_W'(1) && int'(depth) <= DEPTH);

    a_r2_mask_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        active_mask != '0);

    a_r4_split_grows: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid && div && roomy |=> int'(depth) == int'($past(depth)) + 2);

    // R5: the heavier subset (taken on a tie) is fetched next
    a_r5_heavier_on_top: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid && div && roomy |=>
        fetch_pc == (($past($countones(tk)) >= $past($countones(fl))) ?
                     $past(br_taken_pc) : $past(br_fall_pc)));

    a_r7_set_never_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && !div) || (!br_valid && adv_valid) |=>
        int'(depth) == int'($past(depth)) || int'(depth) == int'($past(depth)) - 1);

    a_r9_full_rejected: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid && div && !roomy |=>
        $stable(depth) && $stable(fetch_pc) && $stable(active_mask) && overflow_err);

    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_err |=> overflow_err);

endmodule

bind simt_reconv_stack simt_stack_checker #(
    .LANES (LANES),
    .PC_W  (PC_W),
    .DEPTH (DEPTH)
) u_stack_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .br_valid      (br_valid),
    .br_taken_mask (br_taken_mask),
    .br_taken_pc   (br_taken_pc),
    .br_fall_pc    (br_fall_pc),
    .adv_valid     (adv_valid),
    .fetch_pc      (fetch_pc),
    .active_mask   (active_mask),
    .depth         (depth),
    .overflow_err  (overflow_err)
);

// File: tb/simt_reconv_stack_bench.sv
module simt_reconv_stack_bench;

    localparam int LANES = 4;
    localparam int PC_W  = 12;
    localparam int DEPTH = 6;
    localparam int SP_W  = $clog2(DEPTH + 1);
    localparam logic [15:0] START = 16'h0010;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             br_valid = 1'b0;
    logic [LANES-1:0] br_taken_mask = '0;
    logic [PC_W-1:0]  br_taken_pc = '0;
    logic [PC_W-1:0]  br_fall_pc = '0;
    logic [PC_W-1:0]  br_reconv_pc = '0;
    logic             adv_valid = 1'b0;
    logic [PC_W-1:0]  adv_pc = '0;
    logic [PC_W-1:0]  fetch_pc;
    logic [LANES-1:0] active_mask;
    logic [SP_W-1:0]  depth;
    logic             overflow_err;

    simt_reconv_stack #(
        .LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH), .START_PC(START)
    ) u_simt_reconv_stack (
        .clk(clk), .rst_n(rst_n),
        .br_valid(br_valid), .br_taken_mask(br_taken_mask),
        .br_taken_pc(br_taken_pc), .br_fall_pc(br_fall_pc),
        .br_reconv_pc(br_reconv_pc),
        .adv_valid(adv_valid), .adv_pc(adv_pc),
        .fetch_pc(fetch_pc), .active_mask(active_mask),
        .depth(depth), .overflow_err(overflow_err)
    );

    always #5 clk = ~clk;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // behavioural reference: one queue per row field
    int m_join[$];
    int m_next[$];
    int m_mask[$];
    bit m_err;

    task automatic model_reset();
        m_join = {0};
        m_next = {int'(START[PC_W-1:0])};
        m_mask = {(1 << LANES) - 1};
        m_err  = 0;
    endtask

    task automatic model_set(input int target);
        int top = m_next.size() - 1;
        if (m_next.size() > 1 && target == m_join[top]) begin
            void'(m_join.pop_back());
            void'(m_next.pop_back());
            void'(m_mask.pop_back());
        end else begin
            m_next[top] = target;
        end
    endtask

    task automatic model_tick();
        int top = m_next.size() - 1;
        int all = (1 << LANES) - 1;
        int tk = int'(br_taken_mask) & m_mask[top];
        int fl = ~int'(br_taken_mask) & m_mask[top] & all;
        if (br_valid) begin
            if (tk != 0 && fl != 0) begin
                if (m_next.size() > DEPTH - 2) begin
                    m_err = 1;
                end else begin
                    m_next[top] = int'(br_reconv_pc);
                    if ($countones(tk) >= $countones(fl)) begin
                        m_join.push_back(int'(br_reconv_pc)); m_next.push_back(int'(br_fall_pc));  m_mask.push_back(fl);
                        m_join.push_back(int'(br_reconv_pc)); m_next.push_back(int'(br_taken_pc)); m_mask.push_back(tk);
                    end else begin
                        m_join.push_back(int'(br_reconv_pc)); m_next.push_back(int'(br_taken_pc)); m_mask.push_back(tk);
                        m_join.push_back(int'(br_reconv_pc)); m_next.push_back(int'(br_fall_pc));  m_mask.push_back(fl);
                    end
                end
            end else begin
                model_set(tk != 0 ? int'(br_taken_pc) : int'(br_fall_pc));
            end
        end else if (adv_valid) begin
            model_set(int'(adv_pc));
        end
    endtask

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        int top = m_next.size() - 1;
        chk(tag, "fetch_pc",     int'(fetch_pc),     m_next[top]);
        chk(tag, "active_mask",  int'(active_mask),  m_mask[top]);
        chk(tag, "depth",        int'(depth),        m_next.size());
        chk(tag, "overflow_err", int'(overflow_err), int'(m_err));
    endtask

    task automatic cyc(input string tag);
        @(posedge clk);
        model_tick();
        @(negedge clk);
        compare(tag);
        br_valid  = 1'b0;
        adv_valid = 1'b0;
    endtask

    task automatic do_adv(input int pc, input string tag);
        adv_valid = 1'b1;
        adv_pc    = PC_W'(pc);
        cyc(tag);
    endtask

    task automatic do_br(input int tmask, input int tpc, input int fpc, input int rpc, input string tag);
        br_valid      = 1'b1;
        br_taken_mask = LANES'(tmask);
        br_taken_pc   = PC_W'(tpc);
        br_fall_pc    = PC_W'(fpc);
        br_reconv_pc  = PC_W'(rpc);
        cyc(tag);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare("R1");                                     // reset row
        do_adv(12'h011, "R2");
        do_adv(12'h012, "R2");
        // R10: advance presented together with the branch is dropped
        adv_valid = 1'b1; adv_pc = 12'h099;
        do_br(4'b0101, 12'h020, 12'h060, 12'h070, "R5");  // 2 vs 2 tie
        do_adv(12'h021, "R10");
        do_br(4'b1111, 12'h028, 12'h02c, 12'h070, "R3");  // uniform taken, R11 lanes 1,3
        do_br(4'b1011, 12'h030, 12'h040, 12'h050, "R11"); // only lane 0 taken among 0101
        do_adv(12'h031, "R2");
        do_adv(12'h050, "R7");                             // pop to sibling D
        do_adv(12'h050, "R6");                             // pop to rewritten row E
        do_adv(12'h051, "R2");
        do_adv(12'h070, "R6");                             // pop to path F
        do_br(4'b0000, 12'h0f0, 12'h065, 12'h0ff, "R3");  // uniform not-taken
        do_adv(12'h070, "R7");                             // back to bottom
        do_adv(12'h070, "R8");
        do_adv(12'h000, "R8");                             // equals empty join, no pop
        do_br(4'b0001, 12'h080, 12'h090, 12'h0a0, "R4");  // fall path heavier
        do_br(4'b0110, 12'h0b0, 12'h0c0, 12'h0d0, "R4");  // taken path heavier
        do_br(4'b0010, 12'h0e0, 12'h0e8, 12'h0ec, "R9");  // stack full: rejected
        do_adv(12'h0b4, "R9");                             // flag stays
        do_br(4'b0110, 12'h0d0, 12'h0b8, 12'h000, "R7");  // uniform branch onto join pops
        do_adv(12'h0a0, "R7");
        do_adv(12'h0a0, "R6");
        do_adv(12'h0a4, "R9");
        summary();
    end

endmodule